// File: doc/BRIEF.md
# ADC Autoscan Buffer Controller

This block runs a burst of analog conversions with no processor involvement and stores each result in a local 64-word buffer. A scan covers one to four adjacent mux inputs, starting at a programmable first input. The channel index wraps back to the first input until the programmed number of results has been stored. Each stored word can be the sum of 1, 2, 4 or 8 back-to-back conversions of the same input. The block requests each conversion through a request/done handshake, drives the mux select, writes the result at an incrementing buffer address and pulses a completion flag together with the last write.

Settings are held in shadow inputs and copied into working registers when the enable bit is written to 1. If the enable bit stays set, the shadow settings are copied again at the end of every scan. Software can therefore prepare the next scan, for example a second buffer half for ping-pong use, while the current scan runs. A mode bit selects whether one trigger runs the whole scan or each stored word waits for its own trigger. Writing the enable bit to 0 lets the scan in progress finish, and the block then goes idle.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, conv_req, buf_we and scan_done are 0 and scan_busy is 0.
- R2: Writing en_wdata=1 with en_we while no scan is running copies the shadow settings. The first trigger after that starts a scan whose first conversion uses sh_first_ch. The first word is written at sh_base with bit 0 forced to 0.
- R3: Stored word k of a scan is converted on channel (first + (k mod (sh_last_idx+1))) mod 32. sh_last_idx is the channel count minus one.
- R4: With sh_one_per_sample=0, a single trigger runs every conversion of the scan. Triggers that arrive while the scan runs have no effect.
- R5: With sh_one_per_sample=1, after each stored word (except the last) no conversion is requested until trig is seen again.
- R6: A scan stores exactly sh_count+1 words, at consecutive buffer addresses modulo 64.
- R7: Each stored word is the sum of 2^sh_acc_log2 conversions on the same channel. The write is visible on buf_we/buf_addr/buf_wdata one cycle after the last conv_done.
- R8: scan_done is a one-cycle pulse, asserted in the same cycle as the write of the last word of the scan. scan_busy is 0 from that cycle on.
- R9: Writing en_wdata=0 during a scan does not cut the scan short. After the scan ends, triggers start no conversion until the block is armed again.
- R10: With enable held at 1, shadow changes made during a scan do not affect that scan. They take effect on the next scan, which starts on the next trigger without a new enable write.
- R11: rd_data returns the word stored at rd_addr one cycle after rd_addr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_we | input | 1 | Enable bit write strobe |
| en_wdata | input | 1 | Value written to the enable bit |
| sh_first_ch | input | 5 | Shadow: first mux channel |
| sh_last_idx | input | 2 | Shadow: number of channels minus one |
| sh_base | input | 6 | Shadow: buffer start address (bit 0 ignored) |
| sh_count | input | 6 | Shadow: number of stored words minus one |
| sh_one_per_sample | input | 1 | Shadow: 1 = one trigger per stored word |
| sh_acc_log2 | input | 2 | Shadow: log2 of conversions summed per word |
| trig | input | 1 | Conversion trigger pulse |
| conv_req | output | 1 | One-cycle conversion request |
| conv_ch | output | 5 | Mux channel select |
| conv_done | input | 1 | Conversion finished, conv_data valid |
| conv_data | input | 14 | Conversion result |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | 6 | Buffer write address |
| buf_wdata | output | 17 | Buffer write data (accumulated) |
| rd_addr | input | 6 | Buffer read address |
| rd_data | output | 17 | Buffer read data, one cycle latency |
| scan_done | output | 1 | Scan completion pulse |
| scan_busy | output | 1 | A scan is in progress |

## Verification
The hardest situation to reach is a settings change that overlaps a running scan. It arises when new shadow values, or a disable write, arrive in the same cycle as a conversion result, and the scan then rolls straight into the next one without a new enable write. The bench places the shadow swap and the disable strobe on the first conv_done of a scan. It then follows the current scan channel by channel against the old settings and the next scan against the new ones. Directed scans also cover channel-select wrap past 31 and buffer address wrap past 63 with an odd base. Random scans mix the trigger mode, accumulation depth, count and start address, and inject stray triggers into single-trigger scans.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    S_IDLE      = 2'd0,
    S_ARMED     = 2'd1,
    S_WAIT_TRIG = 2'd2,
    S_CONV      = 2'd3
  } scan_state_e;
endpackage

// File: rtl/adc_scan_cfg.sv
// Working copy of the scan settings, loaded from the shadow inputs.
module adc_scan_cfg #(
  parameter int CH_W   = 5,
  parameter int NCH_W  = 2,
  parameter int ADDR_W = 6,
  parameter int RPT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CH_W-1:0]   sh_first_ch,
  input  logic [NCH_W-1:0]  sh_last_idx,
  input  logic [ADDR_W-1:0] sh_base,
  input  logic [ADDR_W-1:0] sh_count,
  input  logic              sh_one_per_sample,
  input  logic [RPT_W-1:0]  sh_acc_log2,
  output logic [CH_W-1:0]   act_first,
  output logic [NCH_W-1:0]  act_last,
  output logic [ADDR_W-1:0] act_base,
  output logic [ADDR_W-1:0] act_count,
  output logic              act_single,
  output logic [RPT_W-1:0]  act_acc_log2
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_first    <= '0;
      act_last     <= '0;
      act_base     <= '0;
      act_count    <= '0;
      act_single   <= 1'b0;
      act_acc_log2 <= '0;
    end else if (load) begin
      act_first    <= sh_first_ch;
      act_last     <= sh_last_idx;
      act_base     <= sh_base & ALIGN_MASK;
      act_count    <= sh_count;
      act_single   <= sh_one_per_sample;
      act_acc_log2 <= sh_acc_log2;
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
// Scan sequencer: trigger handling, conversion handshake, accumulation,
// channel stepping and buffer address generation.
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int CH_W   = 5,
  parameter int NCH_W  = 2,
  parameter int ADDR_W = 6,
  parameter int RPT_W  = 2,
  parameter int DATA_W = 14,
  parameter int ACC_W  = DATA_W + (1 << RPT_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_we,
  input  logic              en_wdata,
  input  logic              trig,
  input  logic [CH_W-1:0]   act_first,
  input  logic [NCH_W-1:0]  act_last,
  input  logic [ADDR_W-1:0] act_base,
  input  logic [ADDR_W-1:0] act_count,
  input  logic              act_single,
  input  logic [RPT_W-1:0]  act_acc_log2,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              load,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_ch,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [ACC_W-1:0]  buf_wdata,
  output logic              scan_done,
  output logic              scan_busy
);
  localparam int RC_W = (1 << RPT_W) - 1;

  scan_state_e       state_q;
  logic              en_r;
  logic              en_nxt;
  logic [NCH_W-1:0]  ch_idx;
  logic [NCH_W-1:0]  ch_next;
  logic [RC_W-1:0]   rpt_cnt;
  logic [ADDR_W-1:0] smp_cnt;
  logic [ADDR_W-1:0] wr_addr;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  sum_now;
  logic              rpt_last;
  logic              smp_last;
  logic              start_load;
  logic              scan_end;

  assign en_nxt     = en_we ? en_wdata : en_r;
  assign rpt_last   = (rpt_cnt == RC_W'((1 << act_acc_log2) - 1));
  assign smp_last   = (smp_cnt == act_count);
  assign ch_next    = (ch_idx == act_last) ? '0 : ch_idx + 1'b1;
  assign sum_now    = ((rpt_cnt == '0) ? '0 : acc) + ACC_W'(conv_data);
  assign start_load = en_we && en_wdata && (state_q == S_IDLE || state_q == S_ARMED);
  assign scan_end   = (state_q == S_CONV) && conv_done && rpt_last && smp_last;
  assign load       = start_load || (scan_end && en_nxt);
  assign scan_busy  = (state_q == S_CONV) || (state_q == S_WAIT_TRIG);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      en_r      <= 1'b0;
      ch_idx    <= '0;
      rpt_cnt   <= '0;
      smp_cnt   <= '0;
      wr_addr   <= '0;
      acc       <= '0;
      conv_req  <= 1'b0;
      conv_ch   <= '0;
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_wdata <= '0;
      scan_done <= 1'b0;
    end else begin
      en_r      <= en_nxt;
      conv_req  <= 1'b0;
      buf_we    <= 1'b0;
      scan_done <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_load) state_q <= S_ARMED;
        end
        S_ARMED: begin
          if (en_we) begin
            state_q <= en_wdata ? S_ARMED : S_IDLE;
          end else if (trig) begin
            state_q  <= S_CONV;
            conv_req <= 1'b1;
            conv_ch  <= act_first;
            ch_idx   <= '0;
            smp_cnt  <= '0;
            rpt_cnt  <= '0;
            wr_addr  <= act_base;
          end
        end
        S_WAIT_TRIG: begin
          if (trig) begin
            state_q  <= S_CONV;
            conv_req <= 1'b1;
          end
        end
        S_CONV: begin
          if (conv_done) begin
            if (!rpt_last) begin
              acc      <= sum_now;
              rpt_cnt  <= rpt_cnt + 1'b1;
              conv_req <= 1'b1;
            end else begin
              buf_we    <= 1'b1;
              buf_addr  <= wr_addr;
              buf_wdata <= sum_now;
              rpt_cnt   <= '0;
              wr_addr   <= wr_addr + 1'b1;
              smp_cnt   <= smp_cnt + 1'b1;
              ch_idx    <= ch_next;
              conv_ch   <= act_first + CH_W'(ch_next);
              if (smp_last) begin
                scan_done <= 1'b1;
                state_q   <= en_nxt ? S_ARMED : S_IDLE;
              end else if (act_single) begin
                state_q <= S_WAIT_TRIG;
              end else begin
                conv_req <= 1'b1;
              end
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R5: while waiting for a per-sample trigger, no request may be issued
  a_r5_hold_for_trig: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WAIT_TRIG && !trig) |=> !conv_req);

  // R2: a scan always begins at an even buffer address
  a_r2_even_start: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ARMED && trig && !en_we) |=> (wr_addr[0] == 1'b0));

  // R8: completion coincides with the final buffer write
  a_r8_done_with_write: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> buf_we);

  // R3: the channel index never passes the configured last channel
  a_r3_ch_in_range: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> (ch_idx <= act_last));

  // R9: an idle controller issues no conversions
  a_r9_idle_silent: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |-> !conv_req);
endmodule

// File: rtl/adc_scan_buf.sv
// Result buffer: one write port, one registered read port.
module adc_scan_buf #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 17
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int CH_W   = 5,
  parameter int NCH_W  = 2,
  parameter int ADDR_W = 6,
  parameter int RPT_W  = 2,
  parameter int DATA_W = 14,
  parameter int ACC_W  = DATA_W + (1 << RPT_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_we,
  input  logic              en_wdata,
  input  logic [CH_W-1:0]   sh_first_ch,
  input  logic [NCH_W-1:0]  sh_last_idx,
  input  logic [ADDR_W-1:0] sh_base,
  input  logic [ADDR_W-1:0] sh_count,
  input  logic              sh_one_per_sample,
  input  logic [RPT_W-1:0]  sh_acc_log2,
  input  logic              trig,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [ACC_W-1:0]  buf_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ACC_W-1:0]  rd_data,
  output logic              scan_done,
  output logic              scan_busy
);
  logic              load;
  logic [CH_W-1:0]   act_first;
  logic [NCH_W-1:0]  act_last;
  logic [ADDR_W-1:0] act_base;
  logic [ADDR_W-1:0] act_count;
  logic              act_single;
  logic [RPT_W-1:0]  act_acc_log2;

  adc_scan_cfg #(.CH_W(CH_W), .NCH_W(NCH_W), .ADDR_W(ADDR_W), .RPT_W(RPT_W)) u_cfg (
    .clk(clk), .rst(rst), .load(load),
    .sh_first_ch(sh_first_ch), .sh_last_idx(sh_last_idx), .sh_base(sh_base),
    .sh_count(sh_count), .sh_one_per_sample(sh_one_per_sample), .sh_acc_log2(sh_acc_log2),
    .act_first(act_first), .act_last(act_last), .act_base(act_base),
    .act_count(act_count), .act_single(act_single), .act_acc_log2(act_acc_log2)
  );

  adc_scan_seq #(.CH_W(CH_W), .NCH_W(NCH_W), .ADDR_W(ADDR_W), .RPT_W(RPT_W),
                 .DATA_W(DATA_W), .ACC_W(ACC_W)) u_seq (
    .clk(clk), .rst(rst), .en_we(en_we), .en_wdata(en_wdata), .trig(trig),
    .act_first(act_first), .act_last(act_last), .act_base(act_base),
    .act_count(act_count), .act_single(act_single), .act_acc_log2(act_acc_log2),
    .conv_done(conv_done), .conv_data(conv_data), .load(load),
    .conv_req(conv_req), .conv_ch(conv_ch), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .scan_done(scan_done), .scan_busy(scan_busy)
  );

  adc_scan_buf #(.ADDR_W(ADDR_W), .WORD_W(ACC_W)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_addr), .wdata(buf_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: tb/adc_scan_ctrl_tb.sv
module adc_scan_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_we = 1'b0, en_wdata = 1'b0;
  logic [4:0]  sh_first_ch = '0;
  logic [1:0]  sh_last_idx = '0;
  logic [5:0]  sh_base = '0;
  logic [5:0]  sh_count = '0;
  logic        sh_one_per_sample = 1'b0;
  logic [1:0]  sh_acc_log2 = '0;
  logic        trig = 1'b0;
  logic        conv_req;
  logic [4:0]  conv_ch;
  logic        conv_done = 1'b0;
  logic [13:0] conv_data = '0;
  logic        buf_we;
  logic [5:0]  buf_addr;
  logic [16:0] buf_wdata;
  logic [5:0]  rd_addr = '0;
  logic [16:0] rd_data;
  logic        scan_done, scan_busy;

  int checks = 0;
  int errors = 0;
  int exp_mem [64];
  bit exp_vld [64];
  // settings swapped in during a scan (R10)
  int nx_first, nx_last, nx_base, nx_cnt, nx_single, nx_acl;

  always #4 clk = ~clk;

  adc_scan_ctrl u_dut (
    .clk(clk), .rst(rst), .en_we(en_we), .en_wdata(en_wdata),
    .sh_first_ch(sh_first_ch), .sh_last_idx(sh_last_idx), .sh_base(sh_base),
    .sh_count(sh_count), .sh_one_per_sample(sh_one_per_sample), .sh_acc_log2(sh_acc_log2),
    .trig(trig), .conv_req(conv_req), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_data(conv_data), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .scan_done(scan_done), .scan_busy(scan_busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_ch(int first, int last, int s);
    return (first + (s % (last + 1))) % 32;
  endfunction

  function automatic int exp_addr(int base, int s);
    return ((base & 62) + s) % 64;
  endfunction

  task automatic set_shadow(int first, int last, int base, int cnt, int single, int acl);
    sh_first_ch = 5'(first); sh_last_idx = 2'(last); sh_base = 6'(base);
    sh_count = 6'(cnt); sh_one_per_sample = single[0]; sh_acc_log2 = 2'(acl);
  endtask

  task automatic wait_req(int ch, int s);
    int n = 0;
    while (!conv_req && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(conv_req, "R4", $sformatf("request for word %0d", s), conv_req, 1);
    chk(conv_ch == 5'(ch), "R3", $sformatf("channel of word %0d", s), conv_ch, ch);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic do_scan(int first, int last, int base, int cnt, int single, int acl,
                         bit arm, bit mid_swap, bit mid_dis);
    if (arm) begin
      @(negedge clk);
      set_shadow(first, last, base, cnt, single, acl);
      en_we = 1'b1; en_wdata = 1'b1;
      @(negedge clk);
      en_we = 1'b0;
    end
    for (int s = 0; s <= cnt; s++) begin
      int acc = 0;
      if (s == 0 || single != 0) pulse_trig();
      for (int r = 0; r < (1 << acl); r++) begin
        int d;
        wait_req(exp_ch(first, last, s), s);
        repeat ($urandom % 3) @(negedge clk);
        d = int'($urandom % 16384);
        conv_data = 14'(d);
        conv_done = 1'b1;
        if (single == 0 && s > 0 && r == 0) trig = 1'($urandom % 2);
        if (s == 0 && r == 0 && mid_swap)
          set_shadow(nx_first, nx_last, nx_base, nx_cnt, nx_single, nx_acl);
        if (s == 0 && r == 0 && mid_dis) begin
          en_we = 1'b1; en_wdata = 1'b0;
        end
        @(negedge clk);
        conv_done = 1'b0; trig = 1'b0; en_we = 1'b0;
        acc += d;
      end
      chk(buf_we, "R7", "write strobe", buf_we, 1);
      chk(int'(buf_addr) == exp_addr(base, s), "R6", "write address", buf_addr, exp_addr(base, s));
      chk(int'(buf_wdata) == acc, "R7", "accumulated word", buf_wdata, acc);
      chk(scan_done == (s == cnt), "R8", "completion pulse", scan_done, s == cnt);
      exp_mem[exp_addr(base, s)] = acc;
      exp_vld[exp_addr(base, s)] = 1'b1;
      if (s == cnt) begin
        chk(!scan_busy, "R8", "busy after last word", scan_busy, 0);
        @(negedge clk);
        chk(!scan_done, "R8", "completion lasts one cycle", scan_done, 0);
      end else if (single != 0) begin
        bit seen = 1'b0;
        repeat (5) begin
          @(negedge clk);
          if (conv_req) seen = 1'b1;
        end
        chk(!seen, "R5", "request without trigger", seen, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!conv_req, "R1", "conv_req", conv_req, 0);
    chk(!buf_we, "R1", "buf_we", buf_we, 0);
    chk(!scan_done, "R1", "scan_done", scan_done, 0);
    chk(!scan_busy, "R1", "scan_busy", scan_busy, 0);

    // R2 R3 R4: four channels wrapping, one trigger for the whole scan
    do_scan(3, 3, 10, 9, 0, 0, 1'b1, 1'b0, 1'b0);
    // R2 R5 R6 R7: odd base, mux wrap past 31, address wrap past 63, 4x summing
    do_scan(30, 2, 61, 5, 1, 2, 1'b1, 1'b0, 1'b0);

    // R10: shadow changed during scan applies only to the following scan
    nx_first = 7; nx_last = 1; nx_base = 20; nx_cnt = 3; nx_single = 0; nx_acl = 1;
    do_scan(12, 0, 40, 4, 0, 0, 1'b1, 1'b1, 1'b0);
    do_scan(nx_first, nx_last, nx_base, nx_cnt, nx_single, nx_acl, 1'b0, 1'b0, 1'b0);

    // R9: disable during the scan lets it finish, then triggers are ignored
    do_scan(5, 1, 30, 3, 0, 1, 1'b1, 1'b0, 1'b1);
    begin
      bit seen = 1'b0;
      pulse_trig();
      repeat (6) begin
        if (conv_req || scan_busy) seen = 1'b1;
        @(negedge clk);
      end
      chk(!seen, "R9", "activity after disable", seen, 0);
    end

    // random scans, re-armed each time
    for (int k = 0; k < 8; k++) begin
      do_scan(int'($urandom % 32), int'($urandom % 4), int'($urandom % 64),
              int'($urandom % 12), int'($urandom % 2), int'($urandom % 4),
              1'b1, 1'b0, 1'b0);
    end

    // R11: read back every written location
    for (int a = 0; a < 64; a++) begin
      if (exp_vld[a]) begin
        @(negedge clk); rd_addr = 6'(a);
        @(negedge clk);
        chk(int'(rd_data) == exp_mem[a], "R11", $sformatf("buffer word %0d", a), rd_data, exp_mem[a]);
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule